// File: doc/BRIEF.md
# LED Pattern Sequencer Engine

This block is a single-channel micro-sequencer that steps through a small program of 16-bit instructions and produces an 8-bit brightness value. The value is the duty cycle handed to a separate PWM generator. All instruction timing counts a base tick enable (nominally 32768 Hz) that arrives as a one-cycle `tick_en` strobe in the system clock domain. The instruction set covers ramps and waits with prescaled step timing, a direct brightness load, a jump to location 0, a loop branch with a repeat count, a program end, and a trigger instruction that signals a shared trigger unit and stalls on it.

Host-side logic loads the program through a write port and sets the program counter. It then picks one of four control modes: hold, step one instruction, run continuously, or execute one instruction in place. Steps and in-place executions hand control back to hold by themselves, and so does an end instruction. An end instruction can also raise a sticky interrupt flag, which stays set until status-read logic pulses a clear.

The controller is a state machine with six states:
- `ST_IDLE` waits for a non-hold mode. On entry to the next state it latches the instruction at the program counter.
- `ST_DECODE` decodes that instruction, works out the follow-on PC and starts the tick timer.
  - It moves to `ST_RAMP` for ramps and waits.
  - It moves to `ST_TRIG` for trigger instructions.
  - It moves to `ST_TIMED` for everything else.
- `ST_TIMED` waits out the 16-tick period.
- `ST_RAMP` steps the brightness each time the timer expires.
- `ST_TRIG` waits for both the 16-tick period and the awaited triggers.
- `ST_FINISH` commits the PC, the end-instruction effects and the mode reversion, then returns to `ST_IDLE`.

Top module: `led_seq_engine`

## Requirements
- R1: The program memory holds 16 words of 16 bits. The word written at address A is the one executed when the PC equals A, and after executing location 15 with advance the PC becomes 0.
- R2: A ramp word has bit15=0, bit14=prescale, bits13:8=step_time (1..63), bit7=sign, bits6:0=increment. Each step lasts step_time×16 base ticks when prescale is 0 and step_time×512 base ticks when prescale is 1, and brightness changes at the end of each step.
- R3: A ramp with increment N≥1 makes N+1 unit steps, upward for sign 0 and downward for sign 1. A ramp with increment 0 lasts one step period and leaves brightness unchanged.
- R4: During a ramp, brightness saturates at 255 going up and at 0 going down, while the ramp still runs its full number of step periods.
- R5: A word whose upper byte is 0x40 loads its low byte into brightness and takes 16 base ticks. Any other word with bit15=0 and bits13:8=0 (including all-zeros) jumps to location 0 and takes 16 base ticks.
- R6: Control mode encodings are 00 hold, 01 step, 10 run and 11 execute-once, and the current mode is visible on `ctl_mode`.
  - Hold lets the current instruction finish and then stops.
  - Step executes one instruction, advances the PC and reverts to hold.
  - Run keeps executing.
  - Execute-once executes the instruction at the PC, leaves the PC unchanged and reverts to hold.
- R7: A branch word (bits15:13=101, bits12:7=loop count, bits3:0=target) jumps to the target loop-count times and then falls through to PC+1. A loop count of 0 jumps forever.
- R8: An end word (bits15:13=110, bit12=interrupt, bit11=zero) sets the PC to 0 and the mode to hold. It sets the interrupt flag when bit12 is 1, and it forces brightness to 0 when bit11 is 1, otherwise keeping it.
- R9: A PC write is accepted only when the mode is hold and no instruction is in progress; otherwise it is ignored.
- R10: The interrupt flag stays set until an `irq_clr` pulse.
- R11: A trigger word (bits15:13=111, bits12:7=wait mask, bits6:1=send mask) produces a one-cycle `trig_send` with the send mask at start. It then stalls until 16 base ticks have passed and, when the wait mask is nonzero, until `trig_done` has been seen.
- R12: When a counted branch falls through, its loop counter clears, so running the same loop again repeats the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Base tick enable (32768 Hz rate) |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | 4 | Program memory write address |
| prog_data | input | 16 | Program memory write data |
| pc_we | input | 1 | Program counter load strobe |
| pc_wdata | input | 4 | Program counter load value |
| ctl_we | input | 1 | Control mode write strobe |
| ctl_wdata | input | 2 | Control mode write value |
| irq_clr | input | 1 | Interrupt flag clear pulse |
| trig_done | input | 1 | Trigger unit reports awaited triggers arrived |
| ctl_mode | output | 2 | Current control mode |
| pc | output | 4 | Program counter |
| bright | output | 8 | Brightness (PWM duty) value |
| irq | output | 1 | Sticky interrupt flag |
| trig_send | output | 1 | One-cycle trigger send request |
| trig_send_mask | output | 6 | Channels to trigger, valid with trig_send |
| trig_wait | output | 1 | Sequencer is stalled waiting for triggers |
| trig_wait_mask | output | 6 | Channels awaited, valid with trig_wait |

## Verification
The assertions check several rules on every cycle:
- brightness moves by at most one count per cycle during a ramp and holds at 255 once saturated upward;
- the PC holds still outside the finish state unless a load is requested;
- a stepped instruction always returns the mode to hold;
- the interrupt flag never drops without a clear;
- a trigger stall never ends before the trigger arrives;
- the tick timer never counts upward.

Only the bench scenarios can show the rest:
- that step periods scale with step_time and prescale;
- the exact number of ramp steps and loop repetitions;
- that the loop count restarts on re-entry;
- the PC wrap from 15;
- the end-word effects;
- that an ignored PC write really leaves the program flow untouched.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_TIMED,
        ST_RAMP,
        ST_TRIG,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        EX_HOLD = 2'b00,
        EX_STEP = 2'b01,
        EX_RUN  = 2'b10,
        EX_ONCE = 2'b11
    } exec_mode_t;

    typedef enum logic [2:0] {
        OP_RAMP,
        OP_SETBR,
        OP_GOTO,
        OP_BRANCH,
        OP_END,
        OP_TRIG,
        OP_NOP
    } op_t;

    localparam int INSTR_W = 16;

    function automatic op_t decode_op(input logic [INSTR_W-1:0] w);
        op_t op;
        if (!w[15]) begin
            if (w[13:8] != 6'd0)
                op = OP_RAMP;
            else if (w[14])
                op = OP_SETBR;
            else
                op = OP_GOTO;
        end else begin
            unique case (w[14:13])
                2'b01:   op = OP_BRANCH;
                2'b10:   op = OP_END;
                2'b11:   op = OP_TRIG;
                default: op = OP_NOP;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/led_seq_mem.sv
module led_seq_mem #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] rows [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rows[i] <= '0;
            else if (we && waddr == AW'(i))
                rows[i] <= wdata;
        end
    end

    assign rdata = rows[raddr];

endmodule

// File: rtl/led_seq_timer.sv
module led_seq_timer #(
    parameter int CW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick_en && cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign expire = tick_en && (cnt == CW'(1));

    // R2: the period counter only moves downward between loads
    assert_timer_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/led_seq_engine.sv
module led_seq_engine
    import led_seq_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int BRIGHT_W    = 8,
    parameter int FIXED_TICKS = 16,
    parameter int FAST_SHIFT  = 4,
    parameter int SLOW_SHIFT  = 9,
    localparam int AW      = $clog2(DEPTH),
    localparam int STEP_W  = 6,
    localparam int INC_W   = 7,
    localparam int LOOP_W  = 6,
    localparam int MASK_W  = 6,
    localparam int TCW     = STEP_W + SLOW_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                prog_we,
    input  logic [AW-1:0]       prog_addr,
    input  logic [15:0]         prog_data,
    input  logic                pc_we,
    input  logic [AW-1:0]       pc_wdata,
    input  logic                ctl_we,
    input  logic [1:0]          ctl_wdata,
    input  logic                irq_clr,
    input  logic                trig_done,
    output logic [1:0]          ctl_mode,
    output logic [AW-1:0]       pc,
    output logic [BRIGHT_W-1:0] bright,
    output logic                irq,
    output logic                trig_send,
    output logic [MASK_W-1:0]   trig_send_mask,
    output logic                trig_wait,
    output logic [MASK_W-1:0]   trig_wait_mask
);
    localparam logic [BRIGHT_W-1:0] BR_MAX = '1;

    seq_state_t          state, state_nxt;
    exec_mode_t          mode;
    logic [15:0]         instr, mem_rdata;
    logic [AW-1:0]       next_pc_r;
    logic [LOOP_W-1:0]   loop_cnt;
    logic [INC_W-1:0]    steps_left;
    logic                fix_done, trig_seen;
    logic                tim_load, tim_expire;
    logic [TCW-1:0]      tim_val, ramp_period;
    op_t                 op;

    // instruction fields
    logic                f_pre, f_sign, f_int, f_zero;
    logic [STEP_W-1:0]   f_step;
    logic [INC_W-1:0]    f_inc;
    logic [LOOP_W-1:0]   f_loops;
    logic [AW-1:0]       f_target;
    logic [MASK_W-1:0]   f_wait, f_send;

    assign op       = decode_op(instr);
    assign f_pre    = instr[14];
    assign f_step   = instr[13:8];
    assign f_sign   = instr[7];
    assign f_inc    = instr[6:0];
    assign f_loops  = instr[12:7];
    assign f_target = instr[AW-1:0];
    assign f_int    = instr[12];
    assign f_zero   = instr[11];
    assign f_wait   = instr[12:7];
    assign f_send   = instr[6:1];

    assign ramp_period = f_pre ? TCW'({f_step, {SLOW_SHIFT{1'b0}}})
                               : TCW'({f_step, {FAST_SHIFT{1'b0}}});

    led_seq_mem #(.DEPTH(DEPTH), .WIDTH(16)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (prog_we),
        .waddr (prog_addr),
        .wdata (prog_data),
        .raddr (pc),
        .rdata (mem_rdata)
    );

    led_seq_timer #(.CW(TCW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load     (tim_load),
        .load_val (tim_val),
        .expire   (tim_expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state and timer control
    always_comb begin
        state_nxt = state;
        tim_load  = 1'b0;
        tim_val   = TCW'(FIXED_TICKS);
        unique case (state)
            ST_IDLE:   if (mode != EX_HOLD) state_nxt = ST_DECODE;
            ST_DECODE: begin
                tim_load = 1'b1;
                if (op == OP_RAMP) begin
                    tim_val   = ramp_period;
                    state_nxt = ST_RAMP;
                end else if (op == OP_TRIG) begin
                    state_nxt = ST_TRIG;
                end else begin
                    state_nxt = ST_TIMED;
                end
            end
            ST_TIMED:  if (tim_expire) state_nxt = ST_FINISH;
            ST_RAMP: begin
                if (tim_expire) begin
                    if (steps_left == '0) begin
                        state_nxt = ST_FINISH;
                    end else begin
                        tim_load = 1'b1;
                        tim_val  = ramp_period;
                    end
                end
            end
            ST_TRIG: begin
                if ((fix_done || tim_expire) &&
                    (f_wait == '0 || trig_seen || trig_done))
                    state_nxt = ST_FINISH;
            end
            ST_FINISH: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            instr      <= '0;
            pc         <= '0;
            next_pc_r  <= '0;
            mode       <= EX_HOLD;
            bright     <= '0;
            irq        <= 1'b0;
            loop_cnt   <= '0;
            steps_left <= '0;
            fix_done   <= 1'b0;
            trig_seen  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (mode != EX_HOLD)
                        instr <= mem_rdata;
                    else if (pc_we)
                        pc <= pc_wdata;
                end
                ST_DECODE: begin
                    steps_left <= f_inc;
                    fix_done   <= 1'b0;
                    trig_seen  <= 1'b0;
                    next_pc_r  <= pc + AW'(1);
                    unique case (op)
                        OP_SETBR: bright <= instr[BRIGHT_W-1:0];
                        OP_GOTO, OP_END: next_pc_r <= '0;
                        OP_BRANCH: begin
                            if (f_loops == '0) begin
                                next_pc_r <= f_target;
                            end else if (loop_cnt < f_loops) begin
                                next_pc_r <= f_target;
                                loop_cnt  <= loop_cnt + LOOP_W'(1);
                            end else begin
                                loop_cnt  <= '0;
                            end
                        end
                        default: ;
                    endcase
                end
                ST_TIMED: ;
                ST_RAMP: begin
                    if (tim_expire) begin
                        steps_left <= steps_left - INC_W'(1);
                        if (f_inc != '0) begin
                            if (!f_sign && bright != BR_MAX)
                                bright <= bright + BRIGHT_W'(1);
                            else if (f_sign && bright != '0)
                                bright <= bright - BRIGHT_W'(1);
                        end
                    end
                end
                ST_TRIG: begin
                    if (trig_done)  trig_seen <= 1'b1;
                    if (tim_expire) fix_done  <= 1'b1;
                end
                ST_FINISH: begin
                    if (op == OP_END) begin
                        pc   <= '0;
                        mode <= EX_HOLD;
                        if (f_zero) bright <= '0;
                    end else begin
                        if (mode != EX_ONCE) pc <= next_pc_r;
                        if (mode == EX_STEP || mode == EX_ONCE) mode <= EX_HOLD;
                    end
                end
                default: ;
            endcase
            if (ctl_we) mode <= exec_mode_t'(ctl_wdata);
            if (irq_clr) irq <= 1'b0;
            if (state == ST_FINISH && op == OP_END && f_int) irq <= 1'b1;
        end
    end

    assign ctl_mode       = mode;
    assign trig_send      = (state == ST_DECODE) && (op == OP_TRIG) && (f_send != '0);
    assign trig_send_mask = trig_send ? f_send : '0;
    assign trig_wait      = (state == ST_TRIG) && (f_wait != '0);
    assign trig_wait_mask = trig_wait ? f_wait : '0;

    // R3: a ramp moves brightness by at most one count per cycle
    assert_ramp_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAMP) |=> (bright == $past(bright) ||
                                bright == $past(bright) + 1 ||
                                bright == $past(bright) - 1));

    // R4: upward saturation holds at full scale
    assert_ramp_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RAMP && !f_sign && bright == BR_MAX) |=> (bright == BR_MAX));

    // R9: PC only moves on finish or on a load request
    assert_pc_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FINISH && !pc_we) |=> $stable(pc));

    // R6: a stepped instruction hands control back to hold
    assert_step_revert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && mode == EX_STEP && !ctl_we) |=> (mode == EX_HOLD));

    // R10: interrupt flag is sticky
    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R11: no release from a trigger stall before the trigger arrives
    assert_trig_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIG && trig_wait && !trig_done && !trig_seen) |=> (state != ST_FINISH));

endmodule

// File: tb/led_seq_engine_bench.sv
module led_seq_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        prog_we = 1'b0;
    logic [3:0]  prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic        pc_we = 1'b0;
    logic [3:0]  pc_wdata = '0;
    logic        ctl_we = 1'b0;
    logic [1:0]  ctl_wdata = '0;
    logic        irq_clr = 1'b0;
    logic        trig_done = 1'b0;
    logic [1:0]  ctl_mode;
    logic [3:0]  pc;
    logic [7:0]  bright;
    logic        irq;
    logic        trig_send;
    logic [5:0]  trig_send_mask;
    logic        trig_wait;
    logic [5:0]  trig_wait_mask;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc_total = 0;
    int send_cnt = 0;
    logic [5:0] last_send_mask = '0;

    always #4 clk = ~clk;

    led_seq_engine u_led_seq_engine (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .pc_we(pc_we), .pc_wdata(pc_wdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .irq_clr(irq_clr), .trig_done(trig_done), .ctl_mode(ctl_mode), .pc(pc),
        .bright(bright), .irq(irq), .trig_send(trig_send),
        .trig_send_mask(trig_send_mask), .trig_wait(trig_wait),
        .trig_wait_mask(trig_wait_mask)
    );

    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (trig_send) begin
            send_cnt       <= send_cnt + 1;
            last_send_mask <= trig_send_mask;
        end
    end

    initial begin
        wait (cyc_total > 150000);
        n_fail++;
        $display("FAIL watchdog: run hung, act=%0d cycles exp<150000", cyc_total);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        n_tests++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=[%0d..%0d]", req, act, lo, hi);
        end
    endtask

    task automatic wr_mem(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        prog_we = 1'b1; prog_addr = a; prog_data = d;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic wr_pc(input logic [3:0] v);
        @(negedge clk);
        pc_we = 1'b1; pc_wdata = v;
        @(negedge clk);
        pc_we = 1'b0;
    endtask

    task automatic go(input logic [1:0] m);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = m;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wait_hold(input int limit, output int cyc);
        cyc = 1;
        while (ctl_mode != 2'b00 && cyc < limit) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset;
        check("R6 reset mode hold", ctl_mode, 0);
        check("R9 reset pc", pc, 0);
        check("R3 reset bright", bright, 0);
        check("R10 reset irq", irq, 0);
    endtask

    task automatic t_wrap;
        int c;
        wr_mem(4'd15, 16'h4011);
        wr_pc(4'd15);
        go(2'b01);
        wait_hold(100, c);
        check("R1 loaded word executed", bright, 8'h11);
        check("R1 pc wraps 15 to 0", pc, 0);
    endtask

    task automatic t_setbr_step;
        int c;
        wr_mem(4'd0, 16'h40A5);
        wr_pc(4'd0);
        go(2'b01);
        wait_hold(100, c);
        check("R5 set brightness value", bright, 8'hA5);
        check("R6 step advances pc", pc, 1);
        check_range("R5 set brightness 16 ticks", c, 16, 24);
    endtask

    task automatic t_once;
        int c;
        wr_mem(4'd1, 16'h4033);
        go(2'b11);
        wait_hold(100, c);
        check("R6 execute-once applies word", bright, 8'h33);
        check("R6 execute-once keeps pc", pc, 1);
    endtask

    task automatic t_ramp_up;
        int c;
        wr_mem(4'd2, 16'h0103);
        wr_pc(4'd2);
        go(2'b01);
        repeat (26) @(negedge clk);
        check("R2 one step after 16 ticks", bright, 8'h34);
        wait_hold(200, c);
        c += 26;
        check("R3 four steps up", bright, 8'h37);
        check_range("R2 ramp length 4x16 ticks", c, 64, 74);
    endtask

    task automatic t_wait;
        int c;
        wr_mem(4'd3, 16'h0100);
        go(2'b01);
        wait_hold(100, c);
        check("R3 increment 0 keeps brightness", bright, 8'h37);
        check_range("R3 wait lasts one step", c, 16, 24);
    endtask

    task automatic t_prescale;
        int c;
        wr_mem(4'd4, 16'h40FF);
        wr_mem(4'd5, 16'h4181);
        wr_pc(4'd4);
        go(2'b01);
        wait_hold(100, c);
        go(2'b01);
        wait_hold(2000, c);
        check("R3 two steps down", bright, 8'hFD);
        check_range("R2 slow prescale 2x512 ticks", c, 1024, 1034);
    endtask

    task automatic t_sat_down;
        int c;
        wr_mem(4'd6, 16'h4001);
        wr_mem(4'd7, 16'h0183);
        wr_pc(4'd6);
        go(2'b01);
        wait_hold(100, c);
        go(2'b01);
        wait_hold(200, c);
        check("R4 saturate at 0", bright, 0);
        check_range("R4 full duration at floor", c, 64, 74);
    endtask

    task automatic t_sat_up;
        int c;
        wr_mem(4'd0, 16'h40FE);
        wr_mem(4'd1, 16'h0104);
        wr_mem(4'd2, 16'hC000);
        wr_pc(4'd0);
        go(2'b10);
        wait_hold(400, c);
        check("R4 saturate at 255", bright, 8'hFF);
        check_range("R4 full duration at ceiling", c, 112, 130);
        check("R8 end keeps brightness, pc 0", pc, 0);
        check("R8 end without int leaves irq", irq, 0);
    endtask

    task automatic t_branch;
        int c;
        wr_mem(4'd0, 16'h4000);
        wr_mem(4'd1, 16'h0101);
        wr_mem(4'd2, 16'hA181);
        wr_mem(4'd3, 16'hD000);
        wr_pc(4'd0);
        go(2'b10);
        wait_hold(1000, c);
        check("R7 loop body runs 1+3 times", bright, 8);
        check("R8 end sets irq", irq, 1);
        check("R8 end returns pc to 0", pc, 0);
        repeat (20) @(negedge clk);
        check("R10 irq held without clear", irq, 1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check("R10 irq cleared by pulse", irq, 0);
        go(2'b10);
        wait_hold(1000, c);
        check("R12 loop count restarts on rerun", bright, 8);
    endtask

    task automatic t_end_reset;
        int c;
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        wr_mem(4'd0, 16'h4077);
        wr_mem(4'd1, 16'hC800);
        wr_pc(4'd0);
        go(2'b10);
        wait_hold(200, c);
        check("R8 end reset bit zeroes brightness", bright, 0);
        check("R8 end no int bit, irq low", irq, 0);
    endtask

    task automatic t_trigger;
        int c;
        int s0;
        wr_mem(4'd0, 16'hE084);
        wr_pc(4'd0);
        s0 = send_cnt;
        go(2'b01);
        repeat (40) @(negedge clk);
        check("R11 one send pulse", send_cnt - s0, 1);
        check("R11 send mask", last_send_mask, 6'h02);
        check("R11 stalled waiting", trig_wait, 1);
        check("R11 wait mask", trig_wait_mask, 6'h01);
        check("R11 still in step mode", ctl_mode, 1);
        trig_done = 1'b1;
        @(negedge clk);
        trig_done = 1'b0;
        wait_hold(10, c);
        check("R11 released after trigger", ctl_mode, 0);
        check("R11 pc advanced", pc, 1);
    endtask

    task automatic t_forever;
        int c;
        logic [3:0] p;
        wr_mem(4'd0, 16'h4000);
        wr_mem(4'd1, 16'h0101);
        wr_mem(4'd2, 16'hA001);
        wr_pc(4'd0);
        go(2'b10);
        repeat (300) @(negedge clk);
        check("R7 loop count 0 keeps running", ctl_mode, 2);
        pc_we = 1'b1; pc_wdata = 4'd9;
        @(negedge clk);
        pc_we = 1'b0;
        n_tests++;
        if (pc == 4'd9) begin
            n_fail++;
            $display("FAIL R9 pc write while running: act=%0d exp!=9", pc);
        end
        go(2'b00);
        repeat (100) @(negedge clk);
        p = pc;
        repeat (50) @(negedge clk);
        check("R6 hold stops after current word", pc, p);
        n_tests++;
        if (pc > 4'd2) begin
            n_fail++;
            $display("FAIL R9 ignored pc write leaked: act=%0d exp<=2", pc);
        end
        c = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wrap();
        t_setbr_step();
        t_once();
        t_ramp_up();
        t_wait();
        t_prescale();
        t_sat_down();
        t_sat_up();
        t_branch();
        t_end_reset();
        t_trigger();
        t_forever();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule